// File: doc/BRIEF.md
# Hardware Stack and Context Save/Restore Unit

This block owns the stack pointer of a 16-bit-wide data memory and turns stack requests from a pipeline into memory strobes. A single register is pushed or popped in one cycle. A 28-bit program counter and a 4-bit flag field are saved or restored in two beats, because the memory path moves only 16 bits per cycle. Call, return, return-from-interrupt and interrupt entry all use these two-beat operations. The stack grows upward and is empty-ascending: the pointer always names the next free word. It starts at 2047, which is the stack base.

The data memory sits outside the block and has a combinational read port. The block drives `mem_addr`, `mem_wdata`, `mem_we` and `mem_re`, and it samples `mem_rdata` in the same cycle as the read strobe. Results come back one cycle after the beat that produced them:
- a popped word;
- a restored program counter, or the zero vector on interrupt entry;
- restored flags;
- a cause code when a request would overflow or underflow the stack.

The controller is a three-state machine:
- `ST_IDLE` accepts requests.
- `ST_SAVE_HI` writes the second word of a save.
- `ST_LOAD_LO` reads the second word of a restore.

The transitions are:
- A save start (call or interrupt entry) moves `ST_IDLE -> ST_SAVE_HI`.
- A restore start (return or return-from-interrupt) moves `ST_IDLE -> ST_LOAD_LO`.
- Both second-beat states return to `ST_IDLE` unconditionally.
- Every other case stays in `ST_IDLE`, including single-word operations, faults and no request.

Top module: `stack_ctx_unit`

## Requirements
- R1: After reset, `sp_out` is 2047, `busy` is 0, and `fault_code` is 0. No memory strobe and no result valid is raised until a request arrives.
- R2: The request code is `req_op`: 0 none, 1 push, 2 pop, 3 call save, 4 interrupt entry, 5 return, 6 return-from-interrupt. A push (code 1) raises `mem_we` in the request cycle, with `mem_addr` = SP and `mem_wdata` = `push_data`. `sp_out` is SP+1 on the next cycle.
- R3: A pop (code 2) raises `mem_re` in the request cycle with `mem_addr` = SP-1. On the next cycle `pop_valid` is 1, `pop_data` holds the word read, and `sp_out` is SP-1.
- R4: A call save (code 3) takes two beats. The first beat writes `pc_in[15:0]` at SP. The second beat writes `{flags_in, pc_in[27:16]}` at SP+1, with `flags_in` in bits 15:12. `busy` is 1 during the second beat, and `sp_out` ends at SP+2.
- R5: Interrupt entry (code 4) performs the R4 save. On the cycle after its second beat, `pc_valid` is 1 and `pc_out` is 0, while `flags_valid` stays 0.
- R6: A return (code 5) reads SP-1 and then SP-2 on consecutive cycles, and `sp_out` ends at SP-2. One cycle after the second read, `pc_out` = {upper word bits 11:0, lower word} with `pc_valid` = 1. The flag field is ignored (`flags_valid` = 0).
- R7: A return-from-interrupt (code 6) behaves as R6 and also raises `flags_valid`, with `flags_out` equal to bits 15:12 of the upper word.
- R8: A push, call save or interrupt entry is an overflow when SP plus its word count (1 or 2) would exceed 65535. An overflowing request makes no memory access and leaves SP unchanged. `fault_code` is 1 on the next cycle, for one cycle.
- R9: A pop, return or return-from-interrupt is an underflow when SP minus its word count would fall below 2047. An underflowing request makes no memory access and leaves SP unchanged. `fault_code` is 2 on the next cycle, for one cycle.
- R10: A request presented while `busy` is 1 is ignored. The second beat proceeds unchanged, and the ignored request causes no extra strobe and no change to SP.
- R11: A request with code 0 or code 7, or with `req_valid` low, has no effect: no strobe, no result valid, and SP unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Request code (see R2) |
| push_data | input | 16 | Register value for a single push |
| pc_in | input | 28 | Program counter to save |
| flags_in | input | 4 | Flag field to save |
| mem_rdata | input | 16 | Combinational read data from data memory |
| mem_addr | output | 16 | Data memory address |
| mem_wdata | output | 16 | Data memory write data |
| mem_we | output | 1 | Data memory write strobe |
| mem_re | output | 1 | Data memory read strobe |
| busy | output | 1 | Second beat of a save or restore in progress |
| sp_out | output | 16 | Current stack pointer |
| pop_valid | output | 1 | Popped word valid |
| pop_data | output | 16 | Popped word |
| pc_valid | output | 1 | Restored or forced program counter valid |
| pc_out | output | 28 | Restored or forced program counter |
| flags_valid | output | 1 | Restored flags valid |
| flags_out | output | 4 | Restored flags |
| fault_code | output | 4 | 0 none, 1 overflow, 2 underflow |

## Verification
The overflow boundary is the hardest case to reach. It can only be reached by filling the stack from 2047 to 65535 through the ports, since the pointer cannot be loaded directly. The stimulus therefore pushes about 63,500 words. It then shows three things at the top of memory:
- a one-word push at 65535 overflows;
- after one pop, a two-word save at 65534 overflows while a one-word push still fits;
- the words popped back from the top match what was written.

Underflow is exercised by popping at the base, and by a return with only one word on the stack. Requests arriving during the second beat are also driven.

// File: rtl/stack_ctx_pkg.sv
package stack_ctx_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_INTR = 3'd4,
        OP_RET  = 3'd5,
        OP_RTI  = 3'd6
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAVE_HI = 2'd1,
        ST_LOAD_LO = 2'd2
    } stk_state_e;

    typedef enum logic [1:0] {
        WSEL_REG   = 2'd0,
        WSEL_PC_LO = 2'd1,
        WSEL_PC_HI = 2'd2
    } stk_wsel_e;

    localparam logic [3:0] CAUSE_NONE = 4'd0;
    localparam logic [3:0] CAUSE_OVF  = 4'd1;
    localparam logic [3:0] CAUSE_UNF  = 4'd2;

endpackage

// File: rtl/stk_limit_chk.sv
module stk_limit_chk #(
    parameter int ADDR_W  = 16,
    parameter int SP_BASE = 2047,
    parameter int SP_TOP  = 65535
) (
    input  logic [ADDR_W-1:0] sp,
    input  logic [1:0]        words,
    output logic              ovf,
    output logic              unf
);
    localparam int XW = ADDR_W + 1;
    localparam logic [XW-1:0] TOP_X  = XW'(SP_TOP);
    localparam logic [XW-1:0] BASE_X = XW'(SP_BASE);

    logic [XW-1:0] sp_x;
    logic [XW-1:0] words_x;

    always_comb begin
        sp_x    = {1'b0, sp};
        words_x = {{(XW-2){1'b0}}, words};
        ovf     = (sp_x + words_x) > TOP_X;
        unf     = sp_x < (BASE_X + words_x);
    end
endmodule

// File: rtl/stk_word_pack.sv
module stk_word_pack #(
    parameter int DATA_W = 16,
    parameter int PC_W   = 28,
    parameter int FLAG_W = 4
) (
    input  logic [PC_W-1:0]   pc_save,
    input  logic [FLAG_W-1:0] flags_save,
    output logic [DATA_W-1:0] lo_word,
    output logic [DATA_W-1:0] hi_word,
    input  logic [DATA_W-1:0] hi_read,
    input  logic [DATA_W-1:0] lo_read,
    output logic [PC_W-1:0]   pc_rest,
    output logic [FLAG_W-1:0] flags_rest
);
    localparam int PC_HI_W = PC_W - DATA_W;

    always_comb begin
        lo_word    = pc_save[DATA_W-1:0];
        hi_word    = {flags_save, pc_save[PC_W-1:DATA_W]};
        pc_rest    = {hi_read[PC_HI_W-1:0], lo_read};
        flags_rest = hi_read[DATA_W-1 -: FLAG_W];
    end
endmodule

// File: rtl/stk_ctrl_fsm.sv
module stk_ctrl_fsm
    import stack_ctx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  stk_op_e    req_op,
    input  logic       ovf_one,
    input  logic       ovf_two,
    input  logic       unf_one,
    input  logic       unf_two,
    output stk_state_e state_q,
    output logic       mem_we,
    output logic       mem_re,
    output logic       addr_down,
    output stk_wsel_e  wsel,
    output logic       sp_inc,
    output logic       sp_dec,
    output logic       cap_ctx,
    output logic       cap_hi,
    output logic       cap_pop,
    output logic       fin_intr,
    output logic       fin_load,
    output logic       load_flags,
    output logic       fault_up,
    output logic       fault_down
);
    stk_state_e state_d;
    stk_op_e    kind_q;
    stk_op_e    kind_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= OP_NONE;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
        end
    end

    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    case (req_op)
                        OP_CALL, OP_INTR: begin
                            if (!ovf_two) begin
                                state_d = ST_SAVE_HI;
                                kind_d  = req_op;
                            end
                        end
                        OP_RET, OP_RTI: begin
                            if (!unf_two) begin
                                state_d = ST_LOAD_LO;
                                kind_d  = req_op;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_SAVE_HI: state_d = ST_IDLE;
            ST_LOAD_LO: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_we     = 1'b0;
        mem_re     = 1'b0;
        addr_down  = 1'b0;
        wsel       = WSEL_REG;
        sp_inc     = 1'b0;
        sp_dec     = 1'b0;
        cap_ctx    = 1'b0;
        cap_hi     = 1'b0;
        cap_pop    = 1'b0;
        fin_intr   = 1'b0;
        fin_load   = 1'b0;
        load_flags = 1'b0;
        fault_up   = 1'b0;
        fault_down = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    case (req_op)
                        OP_PUSH: begin
                            if (ovf_one) begin
                                fault_up = 1'b1;
                            end else begin
                                mem_we = 1'b1;
                                wsel   = WSEL_REG;
                                sp_inc = 1'b1;
                            end
                        end
                        OP_POP: begin
                            if (unf_one) begin
                                fault_down = 1'b1;
                            end else begin
                                mem_re    = 1'b1;
                                addr_down = 1'b1;
                                sp_dec    = 1'b1;
                                cap_pop   = 1'b1;
                            end
                        end
                        OP_CALL, OP_INTR: begin
                            if (ovf_two) begin
                                fault_up = 1'b1;
                            end else begin
                                mem_we  = 1'b1;
                                wsel    = WSEL_PC_LO;
                                sp_inc  = 1'b1;
                                cap_ctx = 1'b1;
                            end
                        end
                        OP_RET, OP_RTI: begin
                            if (unf_two) begin
                                fault_down = 1'b1;
                            end else begin
                                mem_re    = 1'b1;
                                addr_down = 1'b1;
                                sp_dec    = 1'b1;
                                cap_hi    = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_SAVE_HI: begin
                mem_we   = 1'b1;
                wsel     = WSEL_PC_HI;
                sp_inc   = 1'b1;
                fin_intr = (kind_q == OP_INTR);
            end
            ST_LOAD_LO: begin
                mem_re     = 1'b1;
                addr_down  = 1'b1;
                sp_dec     = 1'b1;
                fin_load   = 1'b1;
                load_flags = (kind_q == OP_RTI);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/stack_ctx_unit.sv
module stack_ctx_unit
    import stack_ctx_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 16,
    parameter int PC_W    = 28,
    parameter int FLAG_W  = 4,
    parameter int SP_BASE = 2047,
    parameter int SP_TOP  = 65535
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [DATA_W-1:0] push_data,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              busy,
    output logic [ADDR_W-1:0] sp_out,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    output logic              pc_valid,
    output logic [PC_W-1:0]   pc_out,
    output logic              flags_valid,
    output logic [FLAG_W-1:0] flags_out,
    output logic [3:0]        fault_code
);
    localparam int N_SIZES = 2;
    localparam logic [ADDR_W-1:0] SP_RESET = ADDR_W'(SP_BASE);

    stk_state_e        state_q;
    stk_wsel_e         wsel;
    logic              addr_down, sp_inc, sp_dec;
    logic              cap_ctx, cap_hi, cap_pop;
    logic              fin_intr, fin_load, load_flags;
    logic              fault_up, fault_down;
    logic [N_SIZES-1:0] ovf_v, unf_v;

    logic [ADDR_W-1:0] sp_q;
    logic [DATA_W-1:0] ctx_hi_q;
    logic [DATA_W-1:0] rd_hi_q;
    logic [DATA_W-1:0] lo_word, hi_word;
    logic [PC_W-1:0]   pc_rest;
    logic [FLAG_W-1:0] flags_rest;

    for (genvar gi = 0; gi < N_SIZES; gi++) begin : g_lim
        stk_limit_chk #(
            .ADDR_W (ADDR_W),
            .SP_BASE(SP_BASE),
            .SP_TOP (SP_TOP)
        ) u_lim (
            .sp   (sp_q),
            .words(2'(gi + 1)),
            .ovf  (ovf_v[gi]),
            .unf  (unf_v[gi])
        );
    end

    stk_word_pack #(
        .DATA_W(DATA_W),
        .PC_W  (PC_W),
        .FLAG_W(FLAG_W)
    ) u_pack (
        .pc_save   (pc_in),
        .flags_save(flags_in),
        .lo_word   (lo_word),
        .hi_word   (hi_word),
        .hi_read   (rd_hi_q),
        .lo_read   (mem_rdata),
        .pc_rest   (pc_rest),
        .flags_rest(flags_rest)
    );

    stk_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (stk_op_e'(req_op)),
        .ovf_one   (ovf_v[0]),
        .ovf_two   (ovf_v[1]),
        .unf_one   (unf_v[0]),
        .unf_two   (unf_v[1]),
        .state_q   (state_q),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .addr_down (addr_down),
        .wsel      (wsel),
        .sp_inc    (sp_inc),
        .sp_dec    (sp_dec),
        .cap_ctx   (cap_ctx),
        .cap_hi    (cap_hi),
        .cap_pop   (cap_pop),
        .fin_intr  (fin_intr),
        .fin_load  (fin_load),
        .load_flags(load_flags),
        .fault_up  (fault_up),
        .fault_down(fault_down)
    );

    // Memory side: address and write data steered by the controller
    always_comb begin
        mem_addr = addr_down ? (sp_q - 1'b1) : sp_q;
        unique case (wsel)
            WSEL_REG:   mem_wdata = push_data;
            WSEL_PC_LO: mem_wdata = lo_word;
            WSEL_PC_HI: mem_wdata = ctx_hi_q;
            default:    mem_wdata = push_data;
        endcase
        busy   = (state_q != ST_IDLE);
        sp_out = sp_q;
    end

    // Stack pointer and captured context words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q     <= SP_RESET;
            ctx_hi_q <= '0;
            rd_hi_q  <= '0;
        end else begin
            if (sp_inc)      sp_q <= sp_q + 1'b1;
            else if (sp_dec) sp_q <= sp_q - 1'b1;
            if (cap_ctx) ctx_hi_q <= hi_word;
            if (cap_hi)  rd_hi_q  <= mem_rdata;
        end
    end

    // Result registers, valid for one cycle after the producing beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pop_valid   <= 1'b0;
            pop_data    <= '0;
            pc_valid    <= 1'b0;
            pc_out      <= '0;
            flags_valid <= 1'b0;
            flags_out   <= '0;
            fault_code  <= CAUSE_NONE;
        end else begin
            pop_valid   <= cap_pop;
            pc_valid    <= fin_intr | fin_load;
            flags_valid <= fin_load & load_flags;
            if (cap_pop) pop_data <= mem_rdata;
            if (fin_intr)      pc_out <= '0;
            else if (fin_load) pc_out <= pc_rest;
            if (fin_load & load_flags) flags_out <= flags_rest;
            if (fault_up)        fault_code <= CAUSE_OVF;
            else if (fault_down) fault_code <= CAUSE_UNF;
            else                 fault_code <= CAUSE_NONE;
        end
    end
endmodule

// File: rtl/stk_ctx_checker.sv
module stk_ctx_checker #(
    parameter int ADDR_W  = 16,
    parameter int SP_BASE = 2047
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic              mem_re,
    input logic              busy,
    input logic [ADDR_W-1:0] sp_out,
    input logic              pop_valid,
    input logic              pc_valid,
    input logic              flags_valid,
    input logic [3:0]        fault_code
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(SP_BASE);

    assert_sp_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sp_out >= BASE_A);

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_out == $past(sp_out) + 1'b1);

    assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> sp_out == $past(sp_out) - 1'b1);

    assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we == 1'b0 && mem_re == 1'b0 |=> sp_out == $past(sp_out));

    assert_busy_short_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_busy_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_we || mem_re));

    assert_flags_with_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_valid |-> pc_valid);

    assert_single_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pop_valid, pc_valid}));

    assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 4'd0) |-> !pop_valid && !pc_valid);
endmodule

bind stack_ctx_unit stk_ctx_checker #(
    .ADDR_W (ADDR_W),
    .SP_BASE(SP_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .busy       (busy),
    .sp_out     (sp_out),
    .pop_valid  (pop_valid),
    .pc_valid   (pc_valid),
    .flags_valid(flags_valid),
    .fault_code (fault_code)
);

// File: tb/sim_stack_ctx_unit.sv
module sim_stack_ctx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [15:0] push_data = '0;
    logic [27:0] pc_in = '0;
    logic [3:0]  flags_in = '0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_we, mem_re, busy;
    logic [15:0] sp_out;
    logic        pop_valid;
    logic [15:0] pop_data;
    logic        pc_valid;
    logic [27:0] pc_out;
    logic        flags_valid;
    logic [3:0]  flags_out;
    logic [3:0]  fault_code;

    always #10 clk = ~clk;

    stack_ctx_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .push_data(push_data), .pc_in(pc_in), .flags_in(flags_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .busy(busy), .sp_out(sp_out),
        .pop_valid(pop_valid), .pop_data(pop_data), .pc_valid(pc_valid),
        .pc_out(pc_out), .flags_valid(flags_valid), .flags_out(flags_out),
        .fault_code(fault_code)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // memory seen by the design, and the model's own expected memory
    logic [15:0] dmem [int];
    logic [15:0] mmem [int];

    // reference model state
    int          m_sp = 2047;
    int          m_phase = 0;   // 0 idle, 1 second save beat, 2 second restore beat
    int          m_kind = 0;
    logic [15:0] m_ctx_hi = '0;
    logic [15:0] m_hi = '0;

    function automatic logic [15:0] rd_d(int a);
        return dmem.exists(a) ? dmem[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] rd_m(int a);
        return mmem.exists(a) ? mmem[a] : 16'h0000;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input int op, input logic [15:0] d,
                        input logic [27:0] pc, input logic [3:0] fl);
        string       tag;
        bit          e_we, e_re, n_popv, n_pcv, n_flv;
        int          e_addr;
        logic [15:0] e_wd, n_popd, lo;
        logic [27:0] n_pc;
        logic [3:0]  n_fl, n_fault;
        int          n_phase;
        e_we = 0; e_re = 0; e_addr = 0; e_wd = '0;
        n_popv = 0; n_popd = '0; n_pcv = 0; n_pc = '0; n_flv = 0; n_fl = '0;
        n_fault = 4'd0; n_phase = 0; tag = "R11";

        @(negedge clk);
        req_valid = v; req_op = op[2:0]; push_data = d; pc_in = pc; flags_in = fl;
        #1;
        mem_rdata = rd_d(int'(mem_addr));
        #1;

        if (m_phase == 0) begin
            if (v) begin
                case (op)
                    1: begin
                        tag = "R2";
                        if (m_sp + 1 > 65535) begin tag = "R8"; n_fault = 4'd1; end
                        else begin
                            e_we = 1; e_addr = m_sp; e_wd = d;
                            mmem[m_sp] = d; m_sp++;
                        end
                    end
                    2: begin
                        tag = "R3";
                        if (m_sp - 1 < 2047) begin tag = "R9"; n_fault = 4'd2; end
                        else begin
                            e_re = 1; e_addr = m_sp - 1;
                            n_popv = 1; n_popd = rd_m(m_sp - 1); m_sp--;
                        end
                    end
                    3, 4: begin
                        tag = (op == 3) ? "R4" : "R5";
                        if (m_sp + 2 > 65535) begin tag = "R8"; n_fault = 4'd1; end
                        else begin
                            e_we = 1; e_addr = m_sp; e_wd = pc[15:0];
                            mmem[m_sp] = pc[15:0]; m_sp++;
                            m_ctx_hi = {fl, pc[27:16]}; m_kind = op; n_phase = 1;
                        end
                    end
                    5, 6: begin
                        tag = (op == 5) ? "R6" : "R7";
                        if (m_sp - 2 < 2047) begin tag = "R9"; n_fault = 4'd2; end
                        else begin
                            e_re = 1; e_addr = m_sp - 1;
                            m_hi = rd_m(m_sp - 1); m_sp--;
                            m_kind = op; n_phase = 2;
                        end
                    end
                    default: tag = "R11";
                endcase
            end
        end else if (m_phase == 1) begin
            tag = v ? "R10" : ((m_kind == 4) ? "R5" : "R4");
            e_we = 1; e_addr = m_sp; e_wd = m_ctx_hi;
            mmem[m_sp] = m_ctx_hi; m_sp++;
            if (m_kind == 4) begin n_pcv = 1; n_pc = '0; end
        end else begin
            tag = v ? "R10" : ((m_kind == 6) ? "R7" : "R6");
            e_re = 1; e_addr = m_sp - 1;
            lo = rd_m(m_sp - 1); m_sp--;
            n_pcv = 1; n_pc = {m_hi[11:0], lo};
            if (m_kind == 6) begin n_flv = 1; n_fl = m_hi[15:12]; end
        end

        chk(tag, "mem_we", 32'(mem_we), 32'(e_we));
        chk(tag, "mem_re", 32'(mem_re), 32'(e_re));
        if (e_we || e_re) chk(tag, "mem_addr", 32'(mem_addr), 32'(e_addr));
        if (e_we) chk(tag, "mem_wdata", 32'(mem_wdata), 32'(e_wd));
        if (mem_we) dmem[int'(mem_addr)] = mem_wdata;

        @(posedge clk);
        #1;
        m_phase = n_phase;
        chk(tag, "sp_out", 32'(sp_out), 32'(m_sp));
        chk(tag, "busy", 32'(busy), 32'(m_phase != 0));
        chk(tag, "fault_code", 32'(fault_code), 32'(n_fault));
        chk(tag, "pop_valid", 32'(pop_valid), 32'(n_popv));
        if (n_popv) chk(tag, "pop_data", 32'(pop_data), 32'(n_popd));
        chk(tag, "pc_valid", 32'(pc_valid), 32'(n_pcv));
        if (n_pcv) chk(tag, "pc_out", 32'(pc_out), 32'(n_pc));
        chk(tag, "flags_valid", 32'(flags_valid), 32'(n_flv));
        if (n_flv) chk(tag, "flags_out", 32'(flags_out), 32'(n_fl));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        chk("R1", "sp_out", 32'(sp_out), 32'd2047);
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "fault_code", 32'(fault_code), 32'd0);
        chk("R1", "mem_we", 32'(mem_we), 32'd0);
        chk("R1", "mem_re", 32'(mem_re), 32'd0);
        chk("R1", "pop_valid", 32'(pop_valid), 32'd0);
        chk("R1", "pc_valid", 32'(pc_valid), 32'd0);
        chk("R1", "flags_valid", 32'(flags_valid), 32'd0);

        // R9 underflow at the base
        step(1, 2, '0, '0, '0);
        step(1, 5, '0, '0, '0);
        step(1, 6, '0, '0, '0);
        step(0, 0, '0, '0, '0);

        // R2 / R3 single pushes and pops
        step(1, 1, 16'h1111, '0, '0);
        step(1, 1, 16'hBEEF, '0, '0);
        step(1, 1, 16'h8001, '0, '0);
        step(1, 2, '0, '0, '0);
        step(1, 2, '0, '0, '0);
        step(1, 1, 16'h7E57, '0, '0);
        step(1, 2, '0, '0, '0);
        step(1, 2, '0, '0, '0);

        // R4 call save with a request arriving during the busy beat (R10)
        step(1, 3, '0, 28'hABC1234, 4'b1010);
        step(1, 1, 16'hDEAD, 28'h0000FFF, 4'b0101);
        // R6 return ignores the flag field
        step(1, 5, '0, '0, '0);
        step(1, 2, '0, '0, '0);

        // R5 interrupt entry, then R7 return-from-interrupt with a busy request
        step(1, 4, '0, 28'h5A5A5A5, 4'b0110);
        step(0, 0, '0, '0, '0);
        step(1, 6, '0, '0, '0);
        step(1, 6, '0, '0, '0);

        // R11 codes 0 and 7, and valid low with a real code
        step(1, 0, 16'h1234, 28'h1234567, 4'hF);
        step(1, 7, 16'h1234, 28'h1234567, 4'hF);
        step(0, 1, 16'h1234, 28'h1234567, 4'hF);

        // R9 restore with a single word on the stack
        step(1, 1, 16'h0F0F, '0, '0);
        step(1, 5, '0, '0, '0);
        step(1, 2, '0, '0, '0);

        // nested saves then restores in reverse order
        step(1, 3, '0, 28'hFFFFFFF, 4'hF);
        step(0, 0, '0, '0, '0);
        step(1, 4, '0, 28'h0000001, 4'h1);
        step(0, 0, '0, '0, '0);
        step(1, 6, '0, '0, '0);
        step(0, 0, '0, '0, '0);
        step(1, 5, '0, '0, '0);
        step(0, 0, '0, '0, '0);

        // R8 fill to the top of memory
        begin
            int k = 0;
            while (m_sp < 65535) begin
                step(1, 1, 16'(k ^ 16'h3C3C), '0, '0);
                k++;
            end
        end
        step(1, 1, 16'hAAAA, '0, '0);
        step(1, 3, '0, 28'h1111111, 4'h2);
        step(1, 2, '0, '0, '0);
        step(1, 4, '0, 28'h2222222, 4'h3);
        step(1, 3, '0, 28'h3333333, 4'h4);
        step(1, 1, 16'h5555, '0, '0);
        step(1, 2, '0, '0, '0);
        step(1, 2, '0, '0, '0);
        step(1, 5, '0, '0, '0);
        step(0, 0, '0, '0, '0);

        finish_run();
    end
endmodule